// File: doc/BRIEF.md
# Dual-Channel Sample Output Formatter

This block is the digital back end of a two-channel 10-bit sampling converter. Each channel has a lane. The lane takes a corrected offset-binary sample and two range indications, over and under. It clamps out-of-range samples to the end codes and carries the code and an out-of-range flag through a fixed-latency pipeline. At the output register it applies the selected coding and drives a parallel word, a flag and a drive-enable for that channel. One select input, `twos_sel`, sets the coding of both channels. When it is low the output is offset binary. When it is high the output is two's complement, which is the offset-binary code with its MSB inverted.

Each lane has its own power sequencer, a small state machine with three states:
- `LANE_OFF`: the lane is idle.
- `LANE_FILL`: the pipeline is refilling after a wake-up.
- `LANE_LIVE`: the lane drives data.

The sequencer has four transitions:
- OFF→FILL happens when the lane is sampled awake.
- FILL→LIVE happens once the lane has been awake on LATENCY consecutive edges.
- FILL→OFF happens when the lane drops out of wake during the fill.
- LIVE→OFF happens when the lane drops out of wake while live.

A lane is awake when `chip_on` is high and its bit of `lane_awake` is high. Outside `LANE_LIVE`, the lane's word and flag are held at zero. So lowering `chip_on` (full power-down) zeroes both channels, and a single asleep lane zeroes only its own channel. Tristate is not modelled as a high-impedance pad. Each channel has a separate drive-enable output instead, which is the registered inverse of that channel's active-low output enable.

Top module: `dual_lane_formatter`

## Requirements
- R1: With `twos_sel` low, an in-range live sample appears unchanged (offset binary, bit 9 the MSB, bit 0 the LSB) with its out-of-range flag low.
- R2: With `twos_sel` high, an in-range live sample appears with only its MSB inverted. For example, 3FF becomes 1FF and 000 becomes 200.
- R3: A sample with its over flag set is forced to all ones. It appears as 3FF in offset binary and 1FF in two's complement, with the flag high. Over takes priority when over and under are both set.
- R4: A sample with only its under flag set is forced to all zeros. It appears as 000 in offset binary and 200 in two's complement, with the flag high.
- R5: A sample captured at rising edge n is on the outputs from just after edge n+LATENCY-1 (edge n+11 by default). The sample's flag appears on that same cycle.
- R6: `twos_sel` is sampled at the output register. A change that is present at edge u applies to the word that leaves edge u, whatever the age of that word.
- R7: An in-range sample following out-of-range ones clears the flag on exactly the cycle it reaches the output.
- R8: From each edge at which `chip_on` is sampled low, both channels' words and flags are zero.
- R9: A lane leaves zero output only after it has been sampled awake on LATENCY consecutive rising edges (OFF→FILL→LIVE). It returns to zero from the first edge at which it is sampled asleep. The state of one lane does not affect the other.
- R10: Each `chN_drive` equals the inverse of `chN_oe_n` at the previous rising edge. The data word is not affected by it.
- R11: During reset all words, flags and drive-enables are zero and both lanes are in `LANE_OFF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge only |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_on | input | 1 | Low forces full power-down of both lanes |
| lane_awake | input | 2 | Per-lane wake, bit i for channel i |
| twos_sel | input | 1 | 0 offset binary, 1 two's complement |
| ch0_raw | input | 10 | Channel 0 corrected sample, offset binary |
| ch0_over | input | 1 | Channel 0 over-range indication |
| ch0_under | input | 1 | Channel 0 under-range indication |
| ch0_oe_n | input | 1 | Channel 0 active-low output enable |
| ch1_raw | input | 10 | Channel 1 corrected sample, offset binary |
| ch1_over | input | 1 | Channel 1 over-range indication |
| ch1_under | input | 1 | Channel 1 under-range indication |
| ch1_oe_n | input | 1 | Channel 1 active-low output enable |
| ch0_code | output | 10 | Channel 0 output word |
| ch0_oor | output | 1 | Channel 0 out-of-range flag |
| ch0_drive | output | 1 | Channel 0 drive-enable (high = driven) |
| ch1_code | output | 10 | Channel 1 output word |
| ch1_oor | output | 1 | Channel 1 out-of-range flag |
| ch1_drive | output | 1 | Channel 1 drive-enable (high = driven) |

## Verification
A sequencer stuck in or leaving `LANE_FILL` at the wrong count shows at the ports straight away. The first live word appears one or more cycles early or late after a wake, or never appears, and the per-cycle comparison flags the very cycle concerned. A delay line that is too short or too long shifts every live word, and the first disagreement shows within one cycle of the lane going live. A flag that is not carried alongside its word shows as a flag that leads or lags the forced code. Sampling the coding select at the wrong stage mis-codes exactly the words near a select toggle.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

    // Lane power sequencer states
    typedef enum logic [1:0] {
        LANE_OFF  = 2'd0,
        LANE_FILL = 2'd1,
        LANE_LIVE = 2'd2
    } lane_state_t;

    localparam int SAMPLE_W_DEF = 10;
    localparam int LATENCY_DEF  = 12;

endpackage

// File: rtl/sample_clamp.sv
// Range clamp: over wins, then under, else the raw offset-binary code.
module sample_clamp #(
    parameter int W = 10
) (
    input  logic [W-1:0] raw,
    input  logic         over,
    input  logic         under,
    output logic [W-1:0] code,
    output logic         oor
);
    always_comb begin
        if (over) begin
            code = '1;
        end else if (under) begin
            code = '0;
        end else begin
            code = raw;
        end
        oor = over | under;
    end
endmodule

// File: rtl/delay_line.sv
// Fixed-depth register chain carrying code and flag together.
module delay_line #(
    parameter int W     = 11,
    parameter int DEPTH = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[i] <= '0;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/lane_sequencer.sv
// Per-lane power sequencer: OFF -> FILL -> LIVE.
module lane_sequencer
    import fmt_pkg::*;
#(
    parameter int LATENCY = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic awake,
    output logic open_next,
    output logic is_live
);
    localparam int CW = (LATENCY > 2) ? $clog2(LATENCY) : 1;
    localparam logic [CW-1:0] FILL_LAST = CW'(LATENCY - 2);

    lane_state_t     state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LANE_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            LANE_OFF: begin
                if (awake) begin
                    state_d = LANE_FILL;
                    cnt_d   = '0;
                end
            end
            LANE_FILL: begin
                if (!awake) begin
                    state_d = LANE_OFF;
                end else if (cnt_q == FILL_LAST) begin
                    state_d = LANE_LIVE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            LANE_LIVE: begin
                if (!awake) state_d = LANE_OFF;
            end
            default: state_d = LANE_OFF;
        endcase
        open_next = (state_d == LANE_LIVE);
        is_live   = (state_q == LANE_LIVE);
    end
endmodule

// File: rtl/lane_out.sv
// Output register: coding select, power gating and drive-enable.
module lane_out #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] code_in,
    input  logic         oor_in,
    input  logic         open,
    input  logic         twos,
    input  logic         oe_n,
    output logic [W-1:0] code_q,
    output logic         oor_q,
    output logic         drive_q
);
    logic [W-1:0] coded;

    always_comb begin
        coded = code_in;
        if (twos) coded[W-1] = ~code_in[W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q  <= '0;
            oor_q   <= 1'b0;
            drive_q <= 1'b0;
        end else begin
            code_q  <= open ? coded : '0;
            oor_q   <= open & oor_in;
            drive_q <= ~oe_n;
        end
    end
endmodule

// File: rtl/dual_lane_formatter.sv
module dual_lane_formatter
    import fmt_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_W_DEF,
    parameter int LATENCY  = LATENCY_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                chip_on,
    input  logic [1:0]          lane_awake,
    input  logic                twos_sel,
    input  logic [SAMPLE_W-1:0] ch0_raw,
    input  logic                ch0_over,
    input  logic                ch0_under,
    input  logic                ch0_oe_n,
    input  logic [SAMPLE_W-1:0] ch1_raw,
    input  logic                ch1_over,
    input  logic                ch1_under,
    input  logic                ch1_oe_n,
    output logic [SAMPLE_W-1:0] ch0_code,
    output logic                ch0_oor,
    output logic                ch0_drive,
    output logic [SAMPLE_W-1:0] ch1_code,
    output logic                ch1_oor,
    output logic                ch1_drive
);
    localparam int LANES  = 2;
    localparam int FLOW_W = SAMPLE_W + 1;
    localparam int DEPTH  = LATENCY - 1;

    logic [SAMPLE_W-1:0] raw_a   [LANES];
    logic [LANES-1:0]    over_a, under_a, oe_n_a;
    logic [SAMPLE_W-1:0] code_a  [LANES];
    logic [LANES-1:0]    oor_a, drive_a;
    logic [LANES-1:0]    lane_live;

    assign raw_a[0] = ch0_raw;
    assign raw_a[1] = ch1_raw;
    assign over_a   = {ch1_over,  ch0_over};
    assign under_a  = {ch1_under, ch0_under};
    assign oe_n_a   = {ch1_oe_n,  ch0_oe_n};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [SAMPLE_W-1:0] clamp_code;
        logic                clamp_oor;
        logic [FLOW_W-1:0]   tail;
        logic                open_next;

        sample_clamp #(.W(SAMPLE_W)) u_clamp (
            .raw   (raw_a[g]),
            .over  (over_a[g]),
            .under (under_a[g]),
            .code  (clamp_code),
            .oor   (clamp_oor)
        );

        delay_line #(.W(FLOW_W), .DEPTH(DEPTH)) u_delay (
            .clk   (clk),
            .rst_n (rst_n),
            .din   ({clamp_oor, clamp_code}),
            .dout  (tail)
        );

        lane_sequencer #(.LATENCY(LATENCY)) u_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .awake     (chip_on & lane_awake[g]),
            .open_next (open_next),
            .is_live   (lane_live[g])
        );

        lane_out #(.W(SAMPLE_W)) u_out (
            .clk     (clk),
            .rst_n   (rst_n),
            .code_in (tail[SAMPLE_W-1:0]),
            .oor_in  (tail[SAMPLE_W]),
            .open    (open_next),
            .twos    (twos_sel),
            .oe_n    (oe_n_a[g]),
            .code_q  (code_a[g]),
            .oor_q   (oor_a[g]),
            .drive_q (drive_a[g])
        );
    end

    assign ch0_code  = code_a[0];
    assign ch1_code  = code_a[1];
    assign ch0_oor   = oor_a[0];
    assign ch1_oor   = oor_a[1];
    assign ch0_drive = drive_a[0];
    assign ch1_drive = drive_a[1];
endmodule

// File: rtl/dual_lane_formatter_chk.sv
module dual_lane_formatter_chk #(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         chip_on,
    input logic [1:0]   lane_awake,
    input logic         ch0_oe_n,
    input logic         ch1_oe_n,
    input logic [W-1:0] ch0_code,
    input logic         ch0_oor,
    input logic         ch0_drive,
    input logic [W-1:0] ch1_code,
    input logic         ch1_oor,
    input logic         ch1_drive,
    input logic [1:0]   lane_live
);
    localparam logic [W-1:0] TOP_ONES = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] TOP_ZERO = {1'b1, {(W-1){1'b0}}};

    assert_powerdown_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_on |=> (ch0_code == '0 && !ch0_oor && ch1_code == '0 && !ch1_oor));

    assert_lane0_asleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_awake[0] |=> (ch0_code == '0 && !ch0_oor));

    assert_lane1_asleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_awake[1] |=> (ch1_code == '0 && !ch1_oor));

    assert_live_needs_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lane_live[0]) |-> $past(chip_on && lane_awake[0]));

    // R3 / R4: a flagged word is always one of the forced end codes
    assert_forced_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ch0_oor |-> (ch0_code == '1 || ch0_code == '0 ||
                     ch0_code == TOP_ONES || ch0_code == TOP_ZERO));

    assert_forced_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ch1_oor |-> (ch1_code == '1 || ch1_code == '0 ||
                     ch1_code == TOP_ONES || ch1_code == TOP_ZERO));

    assert_drive0_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ch0_drive == !$past(ch0_oe_n)));

    assert_drive1_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ch1_drive == !$past(ch1_oe_n)));
endmodule

bind dual_lane_formatter dual_lane_formatter_chk #(.W(SAMPLE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_on    (chip_on),
    .lane_awake (lane_awake),
    .ch0_oe_n   (ch0_oe_n),
    .ch1_oe_n   (ch1_oe_n),
    .ch0_code   (ch0_code),
    .ch0_oor    (ch0_oor),
    .ch0_drive  (ch0_drive),
    .ch1_code   (ch1_code),
    .ch1_oor    (ch1_oor),
    .ch1_drive  (ch1_drive),
    .lane_live  (lane_live)
);

// File: tb/dual_lane_formatter_test.sv
`timescale 1ns/1ps
module dual_lane_formatter_test;
    localparam int W   = 10;
    localparam int LAT = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chip_on = 1'b0;
    logic [1:0] lane_awake = 2'b00;
    logic twos_sel = 1'b0;
    logic [W-1:0] raw [2];
    logic [1:0] over = 2'b00, under = 2'b00, oe_n = 2'b11;
    logic [W-1:0] ch0_code, ch1_code;
    logic ch0_oor, ch1_oor, ch0_drive, ch1_drive;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // Behavioural model state
    logic [W+1:0] hist [2][$];
    int run [2];
    logic [W-1:0] exp_code [2];
    logic exp_oor [2];
    logic exp_drv [2];
    logic [W-1:0] act_code [2];
    logic act_oor [2];
    logic act_drv [2];
    string exp_tag [2];

    always #5 clk = ~clk;

    dual_lane_formatter uut (
        .clk(clk), .rst_n(rst_n), .chip_on(chip_on), .lane_awake(lane_awake),
        .twos_sel(twos_sel),
        .ch0_raw(raw[0]), .ch0_over(over[0]), .ch0_under(under[0]), .ch0_oe_n(oe_n[0]),
        .ch1_raw(raw[1]), .ch1_over(over[1]), .ch1_under(under[1]), .ch1_oe_n(oe_n[1]),
        .ch0_code(ch0_code), .ch0_oor(ch0_oor), .ch0_drive(ch0_drive),
        .ch1_code(ch1_code), .ch1_oor(ch1_oor), .ch1_drive(ch1_drive)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles, expected completion before 20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [W-1:0] clamp_fmt(logic [W-1:0] r, logic hi, logic lo, logic tw);
        logic [W-1:0] c;
        c = hi ? '1 : (lo ? '0 : r);
        if (tw) c[W-1] = ~c[W-1];
        return c;
    endfunction

    task automatic check(string tag, string what, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, actual, expected);
        end
    endtask

    // One clock: model at the rising edge, compare at the following falling edge.
    task automatic cycle(string phase);
        @(posedge clk);
        for (int i = 0; i < 2; i++) begin
            logic [W+1:0] item;
            logic live;
            hist[i].push_back({over[i], under[i], raw[i]});
            if (chip_on && lane_awake[i]) run[i]++; else run[i] = 0;
            item = '0;
            if (hist[i].size() >= LAT) item = hist[i].pop_front();
            live = (run[i] >= LAT);
            exp_drv[i] = !oe_n[i];
            if (live) begin
                exp_code[i] = clamp_fmt(item[W-1:0], item[W+1], item[W], twos_sel);
                exp_oor[i]  = item[W+1] | item[W];
                exp_tag[i]  = item[W+1] ? "R3" : (item[W] ? "R4" : (twos_sel ? "R2" : "R1"));
            end else begin
                exp_code[i] = '0;
                exp_oor[i]  = 1'b0;
                exp_tag[i]  = chip_on ? "R9" : "R8";
            end
        end
        @(negedge clk);
        act_code[0] = ch0_code; act_code[1] = ch1_code;
        act_oor[0]  = ch0_oor;  act_oor[1]  = ch1_oor;
        act_drv[0]  = ch0_drive; act_drv[1] = ch1_drive;
        for (int i = 0; i < 2; i++) begin
            check({exp_tag[i], " ", phase}, $sformatf("ch%0d code", i), act_code[i], exp_code[i]);
            check({exp_tag[i], " ", phase}, $sformatf("ch%0d flag", i), act_oor[i], exp_oor[i]);
            check("R10", $sformatf("ch%0d drive", i), act_drv[i], exp_drv[i]);
        end
    endtask

    task automatic rand_samples(int oor_pct);
        for (int i = 0; i < 2; i++) begin
            raw[i]   = W'($urandom);
            over[i]  = ($urandom % 100) < oor_pct;
            under[i] = ($urandom % 100) < oor_pct;
        end
    endtask

    initial begin
        int found_at;
        raw[0] = '0; raw[1] = '0;
        run[0] = 0; run[1] = 0;

        // R11: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R11", "ch0 code", ch0_code, 0);
        check("R11", "ch1 code", ch1_code, 0);
        check("R11", "flags", {ch0_oor, ch1_oor}, 0);
        check("R11", "drives", {ch0_drive, ch1_drive}, 0);
        rst_n = 1'b1;

        // R1, R9: wake both lanes, offset binary
        chip_on = 1'b1; lane_awake = 2'b11; oe_n = 2'b00;
        for (int k = 0; k < 40; k++) begin rand_samples(0); cycle("offset"); end

        // R2: two's complement, including end codes
        twos_sel = 1'b1;
        raw[0] = 10'h3FF; raw[1] = 10'h000; cycle("twos ends");
        for (int k = 0; k < 30; k++) begin rand_samples(0); cycle("twos"); end

        // R3, R4, R6, R7: range flags and per-cycle format toggling
        for (int k = 0; k < 80; k++) begin
            rand_samples(25);
            twos_sel = $urandom % 2;
            cycle("R6 R7 mixed");
        end
        twos_sel = 1'b0;

        // R9: lane 1 sleeps then wakes, lane 0 stays live
        lane_awake = 2'b01;
        for (int k = 0; k < 20; k++) begin rand_samples(10); cycle("lane1 asleep"); end
        lane_awake = 2'b11;
        for (int k = 0; k < 30; k++) begin rand_samples(10); cycle("lane1 wake"); end
        // R9: short wake pulse shorter than the fill
        lane_awake = 2'b01;
        cycle("lane1 drop");
        lane_awake = 2'b11;
        for (int k = 0; k < 5; k++) begin rand_samples(0); cycle("lane1 short"); end
        lane_awake = 2'b01;
        for (int k = 0; k < 5; k++) begin rand_samples(0); cycle("lane1 abort"); end
        lane_awake = 2'b11;

        // R8: full power-down
        chip_on = 1'b0;
        for (int k = 0; k < 10; k++) begin rand_samples(10); cycle("chip off"); end
        chip_on = 1'b1;
        for (int k = 0; k < 30; k++) begin rand_samples(10); cycle("chip on"); end

        // R10: output enables toggling
        for (int k = 0; k < 30; k++) begin
            rand_samples(10);
            oe_n = 2'($urandom);
            cycle("oe toggle");
        end
        oe_n = 2'b00;

        // R5: single marker, count edges until it shows
        twos_sel = 1'b0; over = 2'b00; under = 2'b00;
        raw[0] = 10'h000; raw[1] = 10'h000;
        for (int k = 0; k < 15; k++) cycle("quiet");
        raw[0] = 10'h2A5;
        cycle("marker");
        found_at = (ch0_code == 10'h2A5) ? 0 : -1;
        raw[0] = 10'h000;
        for (int k = 1; k < 20; k++) begin
            cycle("after marker");
            if (found_at < 0 && ch0_code == 10'h2A5) found_at = k;
        end
        check("R5", "edges from capture to output", found_at, LAT - 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule